// File: doc/BRIEF.md
# Buffer Slot Loan Controller

This block sits beside the input buffers of a four-port mesh router and decides how the physical buffer slots of the four cardinal channels are shared among them. Each channel owns a fixed group of `SLOTS` slots. When a channel is given a depth larger than its group, it borrows unused slots from its two ring neighbours. It asks the neighbour on its right first, and asks the neighbour on its left only for what is still missing. A channel may also run with fewer slots than it owns, and the slots it leaves free become available to its neighbours.

A traffic monitor outside the block supplies one requested depth per channel and pulses `req_valid`. The controller turns these requests into a target allocation and then moves the present allocation towards that target, one slot at a time. A slot leaves a partition only when the partition holds fewer flits than its size. The storage logic reads the allocation outputs to steer its pointers, and it returns the flit count of every partition. While slots are still moving, `busy` is high and new requests are not accepted.

Channels are indexed N=0, E=1, S=2, W=3. Every per-channel port is a flat vector in which channel i occupies bits [i*W +: W]. Here W is `SW` = $clog2(SLOTS+1) for counts and `RW` = $clog2(3*SLOTS+1) for requests. The right neighbour of channel i is (i+3)%4 and the left neighbour is (i+1)%4, so East is right of South and West is left of South.

Top module: `buf_loan_ctrl`

## Requirements
- R1: A channel's own-group partition targets min(request, SLOTS).
- R2: The shortfall (request minus own target) is borrowed first from the right neighbour. Only the part the right neighbour cannot cover is borrowed from the left neighbour. Example with SLOTS=4 and requests N=4, E=2, S=9, W=1: South's right-borrow is 2 and its left-borrow is 3.
- R3: A lender offers only SLOTS minus its own target. When two channels would take the same lender's spare slots, the right-borrow of one channel is served before the left-borrow of the other.
- R4: Each partition changes by at most one slot per clock. Within one physical group at most one partition grows per clock, in the priority own, then right-borrower, then left-borrower. A partition grows only while its group has an unallocated slot.
- R5: A partition shrinks only in a cycle where its reported flit count is below its current size.
- R6: The partitions of any group never sum to more than SLOTS. A channel's granted depth (own + right-borrow + left-borrow) never exceeds 3*SLOTS.
- R7: A request that cannot be met is clamped to what is available. When that happens, the channel's `sat` bit is 1 from the cycle after the request is accepted; otherwise the bit is 0.
- R8: `busy` is 1 whenever any partition differs from its target. A `req_valid` pulse is accepted only while `busy` is 0, and a pulse seen while `busy` is 1 leaves the targets unchanged.
- R9: When all flit counts are zero, a new configuration is reached and `busy` falls within 2*SLOTS+1 clocks after acceptance.
- R10: `lent_left[i]` equals the right-borrow of channel (i+1)%4, and `lent_right[i]` equals the left-borrow of channel (i+3)%4.
- R11: After reset every channel owns SLOTS slots, all borrows and lends are 0, and `busy` and `sat` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | New requested depths are present |
| req_depth | input | 4*RW | Requested depth per channel |
| occ_own | input | 4*SW | Flits held in each channel's own partition |
| occ_rbor | input | 4*SW | Flits held in each channel's right-borrowed partition |
| occ_lbor | input | 4*SW | Flits held in each channel's left-borrowed partition |
| own_cnt | output | 4*SW | Own-group slots used per channel |
| rbor_cnt | output | 4*SW | Slots borrowed from the right neighbour |
| lbor_cnt | output | 4*SW | Slots borrowed from the left neighbour |
| lent_left | output | 4*SW | Own slots held by the left neighbour |
| lent_right | output | 4*SW | Own slots held by the right neighbour |
| sat | output | 4 | Request clamped, per channel |
| busy | output | 1 | A slot move is pending |

## Verification
The assertions assume that each reported flit count never exceeds the current size of its partition. If that assumption is broken, the drain rule cannot keep flits from being dropped. The stimulus only ever holds an occupancy at or below the partition size it last observed. It releases that occupancy only after the moves it blocked have been seen to stall. Requests are accepted only from idle, so the targets the assertions compare against remain fixed while a configuration is in progress.

// File: rtl/buf_loan_ctrl.sv
module buf_loan_ctrl #(
  parameter int SLOTS = 4,
  localparam int SW = $clog2(SLOTS + 1),
  localparam int RW = $clog2(3 * SLOTS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [4*RW-1:0] req_depth,
  input  logic [4*SW-1:0] occ_own,
  input  logic [4*SW-1:0] occ_rbor,
  input  logic [4*SW-1:0] occ_lbor,
  output logic [4*SW-1:0] own_cnt,
  output logic [4*SW-1:0] rbor_cnt,
  output logic [4*SW-1:0] lbor_cnt,
  output logic [4*SW-1:0] lent_left,
  output logic [4*SW-1:0] lent_right,
  output logic [3:0]      sat,
  output logic            busy
);

  function automatic int rt(input int i);
    return (i + 3) % 4;
  endfunction

  function automatic int lf(input int i);
    return (i + 1) % 4;
  endfunction

  logic [3:0][SW-1:0] own_q, br_q, bl_q;
  logic [3:0][SW-1:0] t_own, t_br, t_bl;
  logic [3:0][SW-1:0] own_d, br_d, bl_d;
  logic [3:0][SW-1:0] n_own, n_br, n_bl;
  logic [3:0][SW-1:0] oc_o, oc_r, oc_l;
  logic [3:0]         n_sat, sat_q;
  logic               accept;

  assign oc_o = occ_own;
  assign oc_r = occ_rbor;
  assign oc_l = occ_lbor;

  // target planning: own first, then right neighbour, then left
  always_comb begin
    int ro [4];
    int nd [4];
    int sp [4];
    int rb [4];
    int rest, av, rq;
    for (int i = 0; i < 4; i++) begin
      rq = int'(req_depth[i*RW +: RW]);
      ro[i] = (rq > SLOTS) ? SLOTS : rq;
      nd[i] = rq - ro[i];
      sp[i] = SLOTS - ro[i];
    end
    for (int i = 0; i < 4; i++)
      rb[i] = (nd[i] < sp[rt(i)]) ? nd[i] : sp[rt(i)];
    for (int i = 0; i < 4; i++) begin
      rest = nd[i] - rb[i];
      av = sp[lf(i)] - rb[lf(lf(i))];
      n_own[i] = SW'(ro[i]);
      n_br[i]  = SW'(rb[i]);
      n_bl[i]  = SW'((rest < av) ? rest : av);
      n_sat[i] = rest > av;
    end
  end

  // one-slot steps per partition, one grow per physical group
  always_comb begin
    int fr, b, c;
    logic took;
    own_d = own_q;
    br_d  = br_q;
    bl_d  = bl_q;
    for (int j = 0; j < 4; j++) begin
      b = lf(j);
      c = rt(j);
      fr = SLOTS - int'(own_q[j]) - int'(br_q[b]) - int'(bl_q[c]);
      took = 1'b0;
      if (own_q[j] > t_own[j] && oc_o[j] < own_q[j])
        own_d[j] = own_q[j] - 1'b1;
      else if (own_q[j] < t_own[j] && fr > 0) begin
        own_d[j] = own_q[j] + 1'b1;
        took = 1'b1;
      end
      if (br_q[b] > t_br[b] && oc_r[b] < br_q[b])
        br_d[b] = br_q[b] - 1'b1;
      else if (br_q[b] < t_br[b] && fr > 0 && !took) begin
        br_d[b] = br_q[b] + 1'b1;
        took = 1'b1;
      end
      if (bl_q[c] > t_bl[c] && oc_l[c] < bl_q[c])
        bl_d[c] = bl_q[c] - 1'b1;
      else if (bl_q[c] < t_bl[c] && fr > 0 && !took)
        bl_d[c] = bl_q[c] + 1'b1;
    end
  end

  assign busy   = (own_q != t_own) || (br_q != t_br) || (bl_q != t_bl);
  assign accept = req_valid && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        own_q[i] <= SW'(SLOTS);
        t_own[i] <= SW'(SLOTS);
      end
      br_q  <= '0;
      bl_q  <= '0;
      t_br  <= '0;
      t_bl  <= '0;
      sat_q <= '0;
    end else begin
      own_q <= own_d;
      br_q  <= br_d;
      bl_q  <= bl_d;
      if (accept) begin
        t_own <= n_own;
        t_br  <= n_br;
        t_bl  <= n_bl;
        sat_q <= n_sat;
      end
    end
  end

  assign own_cnt  = own_q;
  assign rbor_cnt = br_q;
  assign lbor_cnt = bl_q;
  assign sat      = sat_q;

  for (genvar g = 0; g < 4; g++) begin : g_ch
    assign lent_left[g*SW +: SW]  = br_q[(g + 1) % 4];
    assign lent_right[g*SW +: SW] = bl_q[(g + 3) % 4];

    assert_group_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      int'(own_q[g]) + int'(br_q[(g + 1) % 4]) + int'(bl_q[(g + 3) % 4]) <= SLOTS);

    assert_own_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(own_q[g]) - int'($past(own_q[g])) <= 1) &&
      (int'($past(own_q[g])) - int'(own_q[g]) <= 1));

    assert_br_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(br_q[g]) - int'($past(br_q[g])) <= 1) &&
      (int'($past(br_q[g])) - int'(br_q[g]) <= 1));

    assert_own_drain_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (own_q[g] < $past(own_q[g])) |-> ($past(oc_o[g]) < $past(own_q[g])));

    assert_br_drain_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (br_q[g] < $past(br_q[g])) |-> ($past(oc_r[g]) < $past(br_q[g])));

    assert_bl_drain_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bl_q[g] < $past(bl_q[g])) |-> ($past(oc_l[g]) < $past(bl_q[g])));
  end

  assert_hold_tgt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ((t_own == $past(t_own)) && (t_br == $past(t_br)) && (t_bl == $past(t_bl))));

  assert_sat_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(accept) |-> $stable(sat));

endmodule

// File: tb/buf_loan_ctrl_bench.sv
module buf_loan_ctrl_bench;
  localparam int SLOTS = 4;
  localparam int SW = $clog2(SLOTS + 1);
  localparam int RW = $clog2(3 * SLOTS + 1);
  localparam int N = 0, E = 1, S = 2, W = 3;

  logic clk = 0, rst_n = 0, req_valid = 0;
  logic [4*RW-1:0] req_depth;
  logic [4*SW-1:0] occ_own, occ_rbor, occ_lbor;
  logic [4*SW-1:0] own_cnt, rbor_cnt, lbor_cnt, lent_left, lent_right;
  logic [3:0] sat;
  logic busy;

  int rq [4];
  int oo [4], orb [4], olb [4];
  int m_own [4], m_br [4], m_bl [4], t_own [4], t_br [4], t_bl [4], m_sat [4];
  int compared = 0, mismatched = 0, cyc = 0;

  always #10 clk = ~clk;

  always_comb
    for (int i = 0; i < 4; i++) begin
      req_depth[i*RW +: RW] = RW'(rq[i]);
      occ_own[i*SW +: SW]  = SW'(oo[i]);
      occ_rbor[i*SW +: SW] = SW'(orb[i]);
      occ_lbor[i*SW +: SW] = SW'(olb[i]);
    end

  buf_loan_ctrl #(.SLOTS(SLOTS)) u_buf_loan_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_depth(req_depth),
    .occ_own(occ_own), .occ_rbor(occ_rbor), .occ_lbor(occ_lbor),
    .own_cnt(own_cnt), .rbor_cnt(rbor_cnt), .lbor_cnt(lbor_cnt),
    .lent_left(lent_left), .lent_right(lent_right), .sat(sat), .busy(busy));

  function automatic int R(int i); return (i + 3) % 4; endfunction
  function automatic int L(int i); return (i + 1) % 4; endfunction
  function automatic int mn(int a, int b); return a < b ? a : b; endfunction
  function automatic int fld(logic [4*SW-1:0] v, int i); return int'(v[i*SW +: SW]); endfunction

  function automatic int m_busy();
    for (int i = 0; i < 4; i++)
      if (m_own[i] != t_own[i] || m_br[i] != t_br[i] || m_bl[i] != t_bl[i]) return 1;
    return 0;
  endfunction

  task automatic chk(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin
      m_own[i] = SLOTS; t_own[i] = SLOTS;
      m_br[i] = 0; m_bl[i] = 0; t_br[i] = 0; t_bl[i] = 0; m_sat[i] = 0;
    end
  endtask

  task automatic model_step();
    int no [4], nb [4], nl [4], ro [4], nd [4], sp [4];
    if (!m_busy() && req_valid) begin
      for (int i = 0; i < 4; i++) begin
        ro[i] = mn(rq[i], SLOTS); nd[i] = rq[i] - ro[i]; sp[i] = SLOTS - ro[i];
      end
      for (int i = 0; i < 4; i++) begin
        t_own[i] = ro[i];
        t_br[i] = mn(nd[i], sp[R(i)]);
      end
      for (int i = 0; i < 4; i++) begin
        int rest, av;
        rest = nd[i] - t_br[i];
        av = sp[L(i)] - t_br[L(L(i))];
        t_bl[i] = mn(rest, av);
        m_sat[i] = rest > av;
      end
    end else begin
      no = m_own; nb = m_br; nl = m_bl;
      for (int j = 0; j < 4; j++) begin
        int f, grown;
        f = SLOTS - m_own[j] - m_br[L(j)] - m_bl[R(j)];
        grown = 0;
        if (m_own[j] > t_own[j] && oo[j] < m_own[j]) no[j]--;
        else if (m_own[j] < t_own[j] && f > 0) begin no[j]++; grown = 1; end
        if (m_br[L(j)] > t_br[L(j)] && orb[L(j)] < m_br[L(j)]) nb[L(j)]--;
        else if (m_br[L(j)] < t_br[L(j)] && f > 0 && !grown) begin nb[L(j)]++; grown = 1; end
        if (m_bl[R(j)] > t_bl[R(j)] && olb[R(j)] < m_bl[R(j)]) nl[R(j)]--;
        else if (m_bl[R(j)] < t_bl[R(j)] && f > 0 && !grown) nl[R(j)]++;
      end
      m_own = no; m_br = nb; m_bl = nl;
    end
  endtask

  task automatic compare_all();
    int bad;
    bad = 0;
    for (int i = 0; i < 4; i++) begin
      if (fld(own_cnt, i) != m_own[i] || fld(rbor_cnt, i) != m_br[i] ||
          fld(lbor_cnt, i) != m_bl[i] || int'(sat[i]) != m_sat[i] ||
          fld(lent_left, i) != m_br[L(i)] || fld(lent_right, i) != m_bl[R(i)]) begin
        bad = 1;
        $display("FAIL R4 cycle %0d ch%0d: actual own/rb/lb/sat %0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d",
                 cyc, i, fld(own_cnt, i), fld(rbor_cnt, i), fld(lbor_cnt, i), sat[i],
                 m_own[i], m_br[i], m_bl[i], m_sat[i]);
      end
    end
    if (int'(busy) != m_busy()) begin
      bad = 1;
      $display("FAIL R8 cycle %0d busy: actual %0d expected %0d", cyc, busy, m_busy());
    end
    compared++;
    if (bad) mismatched++;
  endtask

  task automatic tick();
    @(posedge clk);
    if (rst_n) model_step(); else model_reset();
    @(negedge clk);
    cyc++;
    if (cyc > 100000) begin
      mismatched++;
      $display("FAIL R9 watchdog: actual %0d cycles expected fewer", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
    compare_all();
  endtask

  task automatic request(int n, int e, int s, int w);
    rq[N] = n; rq[E] = e; rq[S] = s; rq[W] = w;
    req_valid = 1;
    tick();
    req_valid = 0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 60) begin tick(); n++; end
  endtask

  task automatic zero_occ();
    for (int i = 0; i < 4; i++) begin oo[i] = 0; orb[i] = 0; olb[i] = 0; end
  endtask

  initial begin
    int n;
    zero_occ();
    for (int i = 0; i < 4; i++) rq[i] = SLOTS;
    model_reset();
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R11 reset state
    for (int i = 0; i < 4; i++) begin
      chk("R11 own after reset", fld(own_cnt, i), SLOTS);
      chk("R11 rbor after reset", fld(rbor_cnt, i), 0);
    end
    chk("R11 busy after reset", int'(busy), 0);
    chk("R11 sat after reset", int'(sat), 0);

    // worked example
    request(4, 2, 9, 1);
    wait_idle(n);
    chk("R9 settle cycles", int'(n <= 2 * SLOTS + 1), 1);
    chk("R1 own E", fld(own_cnt, E), 2);
    chk("R1 own S", fld(own_cnt, S), 4);
    chk("R2 S borrows right", fld(rbor_cnt, S), 2);
    chk("R2 S borrows left", fld(lbor_cnt, S), 3);
    chk("R10 E lent left", fld(lent_left, E), 2);
    chk("R10 W lent right", fld(lent_right, W), 3);
    chk("R7 S not saturated", int'(sat[S]), 0);

    // drain blocking and ignored request while busy
    orb[S] = 2;
    request(4, 4, 4, 4);
    repeat (8) tick();
    chk("R5 rbor S held by flits", fld(rbor_cnt, S), 2);
    chk("R8 busy while blocked", int'(busy), 1);
    request(0, 0, 0, 0);
    zero_occ();
    wait_idle(n);
    chk("R8 ignored request, own N", fld(own_cnt, N), 4);
    chk("R5 rbor S released", fld(rbor_cnt, S), 0);

    // contention on the South group
    request(4, 8, 0, 8);
    wait_idle(n);
    chk("R3 W right-borrow wins", fld(rbor_cnt, W), 4);
    chk("R3 E left-borrow gets none", fld(lbor_cnt, E), 0);
    chk("R7 E saturated", int'(sat[E]), 1);
    chk("R6 group S total", fld(own_cnt, S) + fld(rbor_cnt, W) + fld(lbor_cnt, E), 4);

    // all oversubscribed
    request(15, 15, 15, 15);
    wait_idle(n);
    chk("R7 all saturated", int'(sat), 15);
    chk("R6 no borrow when full", fld(rbor_cnt, N) + fld(lbor_cnt, N), 0);

    // one channel takes everything around it
    request(0, 0, 15, 0);
    wait_idle(n);
    chk("R6 S granted cap", fld(own_cnt, S) + fld(rbor_cnt, S) + fld(lbor_cnt, S), 3 * SLOTS);
    chk("R7 S clamped", int'(sat[S]), 1);
    chk("R9 settle cycles", int'(n <= 2 * SLOTS + 1), 1);

    // mixed patterns with held occupancy
    for (int k = 0; k < 25; k++) begin
      for (int i = 0; i < 4; i++) begin
        oo[i]  = $urandom_range(m_own[i]);
        orb[i] = $urandom_range(m_br[i]);
        olb[i] = $urandom_range(m_bl[i]);
      end
      request($urandom_range(12), $urandom_range(12), $urandom_range(12), $urandom_range(12));
      repeat (5) tick();
      zero_occ();
      wait_idle(n);
      chk("R9 settles after release", int'(busy), 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule